// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard control for a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. It looks at the register indices and control flags held in the three pipeline registers after decode, along with the source indices of the instruction now in decode. From these it decides three things. It picks where each ALU operand in execute comes from. It detects when a load is directly followed by a consumer of its result. It reacts to a taken branch or jump that is resolved in execute.

The only dependencies handled are read-after-write ones. In an in-order pipeline, write-after-write and write-after-read cannot occur. Results still in flight are bypassed to execute, and the younger producer wins. A load feeding the very next instruction cannot be bypassed in time. In that case the controller holds the program counter and the decode register for one cycle and turns the execute slot into a bubble. Fetch always assumes sequential flow. When execute redirects the program counter, the two wrongly fetched instructions in decode and execute are cleared. A redirect outranks a stall request in the same cycle.

The block is combinational. The clock and reset only qualify its bound property checks.

Top module: `hzd_fwd_ctrl`

## Requirements
- R1: With no producer write-enable set and no redirect, both operand selects are 2'b00 (register file), and stall and both clear outputs are 0. This also holds while reset is asserted.
- R2: When the EX/MEM producer has write-enable set, a nonzero destination, and that destination equals an execute source, that operand's select is 2'b10. The two operands are decided independently.
- R3: When only the MEM/WB producer has write-enable set, a nonzero destination, and that destination equals an execute source, that operand's select is 2'b01.
- R4: When both producers match the same execute source, the select is 2'b10, so the EX/MEM value wins.
- R5: A destination of register 0 is never forwarded and never causes a stall.
- R6: A producer whose write-enable is low, as for stores and branches, is never forwarded, even if its destination index matches.
- R7: A load in execute with write-enable set and a nonzero destination equal to either decode source raises stall_o and clear_idex_o and keeps clear_ifid_o low. After the stall, the consumer takes the loaded value with select 2'b01.
- R8: A non-load producer in execute whose destination matches a decode source causes no stall.
- R9: A taken redirect raises both clear_ifid_o and clear_idex_o and forces stall_o low, even when a load-use stall is also requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used to sample the bound checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| id_rs1_i | input | 5 | First source index of the instruction in decode |
| id_rs2_i | input | 5 | Second source index of the instruction in decode |
| ex_rs1_i | input | 5 | First source index held in ID/EX |
| ex_rs2_i | input | 5 | Second source index held in ID/EX |
| ex_rd_i | input | 5 | Destination index held in ID/EX |
| ex_we_i | input | 1 | Register write-enable held in ID/EX |
| ex_load_i | input | 1 | ID/EX instruction is a load |
| mem_rd_i | input | 5 | Destination index held in EX/MEM |
| mem_we_i | input | 1 | Register write-enable held in EX/MEM |
| wb_rd_i | input | 5 | Destination index held in MEM/WB |
| wb_we_i | input | 1 | Register write-enable held in MEM/WB |
| ex_redirect_i | input | 1 | Branch taken or jump resolved in execute |
| fwd_a_o | output | 2 | Operand A source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_b_o | output | 2 | Operand B source, same encoding |
| stall_o | output | 1 | Hold the PC and IF/ID for this cycle |
| clear_ifid_o | output | 1 | Clear IF/ID to a no-op |
| clear_idex_o | output | 1 | Clear ID/EX to a no-op |

## Verification
The forwarding paths are driven in several ways: a match on one operand only, on the other only, on both operands from different stages, and on both stages for the same register. These cases separate independent operand decoding from a shared decision, and they expose a swapped priority. The same matching indices are then presented with write-enable low, and separately with register 0. These cases show that a producer's identity, and not just its index, gates forwarding. The stall cases place the matching load destination against each decode source in turn. They also place a non-load producer with the same match, and a redirect in the same cycle. This separates the stall trigger from the flush trigger and shows which one wins.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned NUM_SRC = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output fwd_sel_e      sel_o
);
  logic hit_mem, hit_wb;

  // writes to register 0 are discarded, so never bypass them
  assign hit_mem = mem_we_i && (mem_rd_i != '0) && (mem_rd_i == src_i);
  assign hit_wb  = wb_we_i  && (wb_rd_i  != '0) && (wb_rd_i  == src_i);

  always_comb begin
    if (hit_mem)     sel_o = FWD_MEM;
    else if (hit_wb) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use
  import hzd_pkg::*;
#(
  parameter int unsigned AW = REG_AW,
  parameter int unsigned NS = NUM_SRC
) (
  input  logic [NS-1:0][AW-1:0] id_src_i,
  input  logic [AW-1:0]         ex_rd_i,
  input  logic                  ex_we_i,
  input  logic                  ex_load_i,
  output logic                  hazard_o
);
  logic          prod_ok;
  logic [NS-1:0] src_hit;

  assign prod_ok = ex_load_i && ex_we_i && (ex_rd_i != '0);

  for (genvar g = 0; g < NS; g++) begin : g_src
    assign src_hit[g] = (id_src_i[g] == ex_rd_i);
  end

  assign hazard_o = prod_ok && (|src_hit);
endmodule

// File: rtl/hzd_flow_ctrl.sv
module hzd_flow_ctrl (
  input  logic redirect_i,
  input  logic load_use_i,
  output logic stall_o,
  output logic clear_ifid_o,
  output logic clear_idex_o
);
  // redirect kills the stalled decode instruction anyway
  assign stall_o      = load_use_i && !redirect_i;
  assign clear_ifid_o = redirect_i;
  assign clear_idex_o = redirect_i || load_use_i;
endmodule

// File: rtl/hzd_fwd_ctrl.sv
module hzd_fwd_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic [AW-1:0] ex_rs1_i,
  input  logic [AW-1:0] ex_rs2_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  input  logic          ex_redirect_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          stall_o,
  output logic          clear_ifid_o,
  output logic          clear_idex_o
);
  localparam int unsigned NS = NUM_SRC;

  logic [NS-1:0][AW-1:0] ex_src, id_src;
  fwd_sel_e [NS-1:0]     sel;
  logic                  load_use;

  assign ex_src[0] = ex_rs1_i;
  assign ex_src[1] = ex_rs2_i;
  assign id_src[0] = id_rs1_i;
  assign id_src[1] = id_rs2_i;

  for (genvar g = 0; g < NS; g++) begin : g_opnd
    hzd_fwd_unit #(.AW(AW)) u_fwd (
      .src_i    (ex_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel[g])
    );
  end

  assign fwd_a_o = sel[0];
  assign fwd_b_o = sel[1];

  hzd_load_use #(.AW(AW), .NS(NS)) u_lu (
    .id_src_i  (id_src),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .hazard_o  (load_use)
  );

  hzd_flow_ctrl u_flow (
    .redirect_i   (ex_redirect_i),
    .load_use_i   (load_use),
    .stall_o      (stall_o),
    .clear_ifid_o (clear_ifid_o),
    .clear_idex_o (clear_idex_o)
  );
endmodule

// File: rtl/hzd_fwd_ctrl_chk.sv
module hzd_fwd_ctrl_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] id_rs1_i,
  input logic [AW-1:0] id_rs2_i,
  input logic [AW-1:0] ex_rs1_i,
  input logic [AW-1:0] ex_rs2_i,
  input logic [AW-1:0] ex_rd_i,
  input logic          ex_we_i,
  input logic          ex_load_i,
  input logic [AW-1:0] mem_rd_i,
  input logic          mem_we_i,
  input logic [AW-1:0] wb_rd_i,
  input logic          wb_we_i,
  input logic          ex_redirect_i,
  input logic [1:0]    fwd_a_o,
  input logic [1:0]    fwd_b_o,
  input logic          stall_o,
  input logic          clear_ifid_o,
  input logic          clear_idex_o
);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_i && !wb_we_i && !ex_we_i && !ex_redirect_i) |->
      (fwd_a_o == 2'b00 && fwd_b_o == 2'b00 && !stall_o && !clear_ifid_o && !clear_idex_o));

  p_mem_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o == 2'b10) |-> (mem_we_i && mem_rd_i == ex_rs1_i));

  p_wb_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_b_o == 2'b01) |-> (wb_we_i && wb_rd_i == ex_rs2_i));

  p_priority_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && mem_rd_i != '0 && mem_rd_i == ex_rs1_i) |-> (fwd_a_o == 2'b10));

  p_x0_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs1_i == '0) |-> (fwd_a_o == 2'b00));

  p_x0_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs2_i == '0) |-> (fwd_b_o == 2'b00));

  p_no_we_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_i && !wb_we_i) |-> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

  p_stall_shape_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (clear_idex_o && !clear_ifid_o));

  p_stall_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_load_i && ex_we_i && ex_rd_i != '0));

  p_redirect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_redirect_i |-> (clear_ifid_o && clear_idex_o && !stall_o));
endmodule

bind hzd_fwd_ctrl hzd_fwd_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_hzd_fwd_ctrl.sv
module sim_hzd_fwd_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] id_rs1_i, id_rs2_i, ex_rs1_i, ex_rs2_i, ex_rd_i, mem_rd_i, wb_rd_i;
  logic       ex_we_i, ex_load_i, mem_we_i, wb_we_i, ex_redirect_i;
  logic [1:0] fwd_a_o, fwd_b_o;
  logic       stall_o, clear_ifid_o, clear_idex_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  hzd_fwd_ctrl u0 (.*);

  typedef struct packed {
    logic [7:0] req;
    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd;
    logic       ex_we, ex_ld;
    logic [4:0] mem_rd;
    logic       mem_we;
    logic [4:0] wb_rd;
    logic       wb_we, redir;
    logic [1:0] e_a, e_b;
    logic       e_stall, e_ifid, e_idex;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R1 idle
    '{8'd1, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0},
    // R2 operand A from EX/MEM
    '{8'd2, 5'd1, 5'd2, 5'd5, 5'd6, 5'd0, 1'b0, 1'b0, 5'd5, 1'b1, 5'd0, 1'b0, 1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0},
    // R2 operand B from EX/MEM
    '{8'd2, 5'd1, 5'd2, 5'd5, 5'd6, 5'd0, 1'b0, 1'b0, 5'd6, 1'b1, 5'd0, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0},
    // R3 both from MEM/WB
    '{8'd3, 5'd1, 5'd2, 5'd7, 5'd7, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd7, 1'b1, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0},
    // R4 same register in both stages
    '{8'd4, 5'd1, 5'd2, 5'd9, 5'd3, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1, 5'd9, 1'b1, 1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0},
    // R4 mixed sources per operand
    '{8'd4, 5'd1, 5'd2, 5'd9, 5'd4, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 5'd9, 1'b1, 1'b0, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0},
    // R5 x0 destinations not forwarded
    '{8'd5, 5'd1, 5'd2, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0},
    // R5 load to x0 causes no stall
    '{8'd5, 5'd0, 5'd0, 5'd1, 5'd2, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0},
    // R6 store/branch producers ignored
    '{8'd6, 5'd1, 5'd2, 5'd8, 5'd8, 5'd0, 1'b0, 1'b0, 5'd8, 1'b0, 5'd8, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0},
    // R7 load-use on decode source 1
    '{8'd7, 5'd12, 5'd2, 5'd1, 5'd2, 5'd12, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1},
    // R7 load-use on decode source 2
    '{8'd7, 5'd1, 5'd13, 5'd1, 5'd2, 5'd13, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1},
    // R8 ALU producer, no stall
    '{8'd8, 5'd12, 5'd2, 5'd1, 5'd2, 5'd12, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0},
    // R9 redirect alone
    '{8'd9, 5'd1, 5'd2, 5'd1, 5'd2, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1},
    // R9 redirect beats load-use
    '{8'd9, 5'd12, 5'd2, 5'd1, 5'd2, 5'd12, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1},
    // R2 with R7: bypass and stall in the same cycle
    '{8'd7, 5'd1, 5'd14, 5'd3, 5'd2, 5'd14, 1'b1, 1'b1, 5'd3, 1'b1, 5'd0, 1'b0, 1'b0, 2'b10, 2'b00, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    id_rs1_i = v.id_rs1; id_rs2_i = v.id_rs2;
    ex_rs1_i = v.ex_rs1; ex_rs2_i = v.ex_rs2; ex_rd_i = v.ex_rd;
    ex_we_i = v.ex_we; ex_load_i = v.ex_ld;
    mem_rd_i = v.mem_rd; mem_we_i = v.mem_we;
    wb_rd_i = v.wb_rd; wb_we_i = v.wb_we;
    ex_redirect_i = v.redir;
  endtask

  task automatic check_all(input vec_t v);
    check(int'(v.req), "fwd_a", {6'd0, fwd_a_o}, {6'd0, v.e_a});
    check(int'(v.req), "fwd_b", {6'd0, fwd_b_o}, {6'd0, v.e_b});
    check(int'(v.req), "stall", {7'd0, stall_o}, {7'd0, v.e_stall});
    check(int'(v.req), "clear_ifid", {7'd0, clear_ifid_o}, {7'd0, v.e_ifid});
    check(int'(v.req), "clear_idex", {7'd0, clear_idex_o}, {7'd0, v.e_idex});
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    apply(VECS[0]);
    // R1: idle outputs while in reset
    #12;
    check_all(VECS[0]);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      #2;
      check_all(VECS[i]);
      @(negedge clk_i);
    end

    // R7: after the stall, the load is in MEM/WB and the consumer is in EX
    apply(VECS[0]);
    ex_rs1_i = 5'd12; ex_rs2_i = 5'd12;
    wb_rd_i = 5'd12; wb_we_i = 1'b1;
    #2;
    check(7, "post-stall fwd_a", {6'd0, fwd_a_o}, 8'h01);
    check(7, "post-stall fwd_b", {6'd0, fwd_b_o}, 8'h01);
    check(7, "post-stall stall", {7'd0, stall_o}, 8'h00);
    @(negedge clk_i);

    // R6: a matching store in EX/MEM must not hide an older writer in MEM/WB
    apply(VECS[0]);
    ex_rs1_i = 5'd10; mem_rd_i = 5'd10; mem_we_i = 1'b0;
    wb_rd_i = 5'd10; wb_we_i = 1'b1;
    #2;
    check(6, "store in EX/MEM, fwd_a", {6'd0, fwd_a_o}, 8'h01);
    @(negedge clk_i);

    // R1: back to idle
    apply(VECS[0]);
    #2;
    check_all(VECS[0]);
    @(negedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule